// File: doc/BRIEF.md
# Convergence Fraction Divider

This block divides one unsigned binary fraction by another without any subtraction. It scales the dividend and the divisor by the same correction factor over and over. The factor is chosen so that the scaled divisor moves towards one, and the scaled dividend therefore moves towards the quotient. The number of leading ones in the divisor at least doubles with each pass, so a W-bit result needs about log2(W) passes.

One W x (W+1) multiplier is shared by both products. It works on one product per clock cycle. A caller presents the two operands with a one-cycle start pulse while the block is idle. The block then stays busy for a fixed number of cycles and signals the result with a one-cycle done pulse. The quotient stays on its port until the next accepted start. Only the quotient is produced, and no remainder is formed.

Top module: `frac_conv_div`

## Requirements
- R1: The divisor must be normalized, with bit W-1 (weight 1/2) set, so that 1/2 <= D < 1. The dividend must be smaller than the divisor. Bit W-1 of either operand has weight 2^-1, and bit 0 has weight 2^-W.
- R2: A start pulse seen while busy is low loads both operands, and busy reads high from the next cycle.
- R3: The pass count is fixed at P = ceil(log2 W) + 1 (P = 5 for W = 15). The divisor product is skipped in the last pass. Done is therefore high in the cycle after the (2P-1)-th rising edge that follows the accepting edge, and busy falls in that same cycle, whatever the operand values.
- R4: Each pass forms F = 2 - D as a value with one integer bit and W fraction bits. It replaces N with N*F and D with D*F, and truncates each product to W fraction bits. The quotient equals the bit-exact result of this sequence.
- R5: For W = 15, dividend 0x3400 (0.40625) and divisor 0x6000 (0.75) give quotient 0x4555.
- R6: The quotient lies within 4*P units in the last place of floor(N * 2^W / D).
- R7: A start pulse that arrives while busy is high has no effect: the running result is unchanged and no extra done pulse follows.
- R8: Done is a single-cycle pulse. While idle and without start, the quotient port does not change.
- R9: After a synchronous active-low reset, busy, done and quotient all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | W | Numerator fraction N |
| divisor | input | W | Denominator fraction D, normalized |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: quotient is valid |
| quotient | output | W | Quotient fraction, held until the next start |

## Verification
The worked operand pair pins down the exact bit pattern that the truncated scaling sequence must produce. Extreme divisors are tried next: 0x4000, which has the fewest leading ones, and 0x7FFF, which starts already converged. These show whether a pass is missing or a factor is formed wrongly. A zero dividend and a one-ulp dividend separate numerator handling from divisor handling. Pseudo-random normalized pairs, issued back to back, compare every result against a bench model of the truncated sequence and against the ideal floor quotient. A start pulse injected mid-run shows whether the block ignores requests while it is busy.

// File: rtl/fcd_pkg.sv
// Package: shared sizing helpers for the convergence divider.
// Assumes widths of at least 2 bits.
package fcd_pkg;
    // Number of scaling passes: ceil(log2 w) plus one guard pass.
    function automatic int pass_count(input int w);
        return $clog2(w) + 1;
    endfunction

    // Multiplier occupancy: two products per pass, minus the skipped last divisor product.
    function automatic int step_count(input int w);
        return 2 * pass_count(w) - 1;
    endfunction
endpackage

// File: rtl/fcd_factor.sv
// Module: forms the correction factor F = 2 - D.
// Assumes D is a W-bit fraction in [1/2, 1). F then has 1 integer bit and
// W fraction bits and stays in (1, 1.5], so it fits in W+1 bits.
module fcd_factor #(
    parameter int W = 15
) (
    input  logic [W-1:0] den,
    output logic [W:0]   fac
);
    // Two's complement of the fraction, taken modulo 2^(W+1).
    always_comb begin
        fac = (W+1)'(0) - {1'b0, den};
    end
endmodule

// File: rtl/fcd_mul.sv
// Module: truncating fraction multiplier shared by both products.
// a is a W-bit fraction and b is 1.W fixed point. The product is cut back to W
// fraction bits. ovf flags a product that reached 1.0 or more.
module fcd_mul #(
    parameter int W = 15
) (
    input  logic [W-1:0] a,
    input  logic [W:0]   b,
    output logic [W-1:0] p,
    output logic         ovf
);
    localparam int PW = 2 * W + 1;
    logic [PW-1:0] full;

    // Full-precision product followed by truncation of the low W bits.
    always_comb begin
        full = {{(W+1){1'b0}}, a} * {{W{1'b0}}, b};
        p    = full[2*W-1:W];
        ovf  = full[2*W];
    end
endmodule

// File: rtl/fcd_ctrl.sv
// Module: sequencer for the convergence divider.
// Counts the STEPS multiplier cycles of one division. Even steps scale the
// numerator, odd steps scale the denominator. The final step is even, so the
// last denominator product is never formed. Start is honoured only when idle.
module fcd_ctrl #(
    parameter int STEPS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic num_phase,
    output logic last_step
);
    localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

    logic [SW-1:0] step_q;
    logic          busy_q;
    logic          done_q;

    // Decode the current step for the datapath.
    always_comb begin
        load      = start && !busy_q;
        num_phase = !step_q[0];
        last_step = (step_q == LAST);
        busy      = busy_q;
        done      = done_q;
    end

    // Step counter, busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                busy_q <= 1'b1;
                step_q <= '0;
            end else if (busy_q) begin
                if (last_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last_step) |=> (busy_q && !done_q));
    p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q);
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> (busy_q && step_q == '0));
endmodule

// File: rtl/frac_conv_div.sv
// Module: top of the convergence fraction divider.
// Scales numerator and denominator by F = 2 - D on each pass, using one shared
// truncating multiplier, until the denominator is all ones. The numerator is
// then the quotient. Assumes a normalized divisor and dividend < divisor.
module frac_conv_div #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    import fcd_pkg::*;
    localparam int STEPS = step_count(W);

    logic [W-1:0] num_q;
    logic [W-1:0] den_q;
    logic [W:0]   fac;
    logic [W-1:0] mul_a;
    logic [W-1:0] prod;
    logic         ovf;
    logic         load;
    logic         num_phase;
    logic         last_step;

    fcd_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .load      (load),
        .num_phase (num_phase),
        .last_step (last_step)
    );

    fcd_factor #(.W(W)) u_factor (
        .den (den_q),
        .fac (fac)
    );

    // Route the operand due for scaling in this step into the multiplier.
    always_comb begin
        mul_a = num_phase ? num_q : den_q;
    end

    fcd_mul #(.W(W)) u_mul (
        .a   (mul_a),
        .b   (fac),
        .p   (prod),
        .ovf (ovf)
    );

    // Operand registers: load on accept, then write back one product per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q <= '0;
            den_q <= '0;
        end else if (load) begin
            num_q <= dividend;
            den_q <= divisor;
        end else if (busy) begin
            if (num_phase) num_q <= prod;
            else           den_q <= prod;
        end
    end

    // The running numerator is the quotient output.
    always_comb begin
        quotient = num_q;
    end

    p_norm_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (divisor[W-1] && dividend < divisor));
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ovf);
    p_den_rises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !num_phase) |=> (den_q >= $past(den_q)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(quotient));
endmodule

// File: tb/sim_frac_conv_div.sv
module sim_frac_conv_div;
    localparam int W          = 15;
    localparam int CLK_PERIOD = 10;
    localparam int P          = $clog2(W) + 1;
    localparam int LAT        = 2 * P - 1;

    typedef struct {
        logic [W-1:0] exp_q;
        longint       ideal;
        longint       t_issue;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;

    int     n_checks = 0;
    int     n_fail = 0;
    longint cyc = 0;
    item_t  sbq[$];
    logic   prev_done = 1'b0;

    frac_conv_div #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .quotient(quotient)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Bench model of the truncated scaling sequence (R4).
    function automatic longint model(input longint n, input longint d);
        longint f;
        for (int i = 0; i < P; i++) begin
            f = (longint'(1) << (W + 1)) - d;
            n = (n * f) >> W;
            if (i != P - 1) d = (d * f) >> W;
        end
        return n;
    endfunction

    // Driver: wait for idle, pulse start and push the expected result.
    task automatic issue(input longint n, input longint d, input string tag);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        dividend = W'(n);
        divisor  = W'(d);
        start    = 1'b1;
        it.exp_q   = W'(model(n, d));
        it.ideal   = (n << W) / d;
        it.t_issue = cyc;
        it.tag     = tag;
        sbq.push_back(it);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: pop and compare on each done pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(prev_done && done), "R8 done single cycle", done, 0);
            if (done) begin
                if (sbq.size() == 0) begin
                    check(0, "R7 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    longint diff;
                    it = sbq.pop_front();
                    check(quotient == it.exp_q, {"R4 quotient ", it.tag}, quotient, it.exp_q);
                    diff = longint'(quotient) - it.ideal;
                    if (diff < 0) diff = -diff;
                    check(diff <= 4 * P, {"R6 accuracy ", it.tag}, quotient, it.ideal);
                    check(cyc - it.t_issue == LAT + 1, "R3 latency", cyc - it.t_issue, LAT + 1);
                    check(!busy, "R3 busy low with done", busy, 0);
                end
            end
        end
        prev_done = done;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 100000);
        check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        int unsigned  x;
        longint       d;
        longint       n;
        repeat (3) @(negedge clk);
        check(busy == 0, "R9 busy reset", busy, 0);
        check(done == 0, "R9 done reset", done, 0);
        check(quotient == 0, "R9 quotient reset", quotient, 0);
        rst_n = 1'b1;

        // R2: accept and busy next cycle.
        @(negedge clk);
        dividend = W'(15'h3400);
        divisor  = W'(15'h6000);
        start = 1'b1;
        begin
            item_t it;
            it.exp_q = W'(model(64'h3400, 64'h6000));
            it.ideal = (longint'(15'h3400) << W) / 15'h6000;
            it.t_issue = cyc;
            it.tag = "R5 example";
            sbq.push_back(it);
        end
        @(negedge clk);
        start = 1'b0;
        check(busy == 1, "R2 busy after start", busy, 1);
        // R7: start while busy with other operands is ignored.
        @(negedge clk);
        dividend = W'(15'h1000);
        divisor  = W'(15'h7000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        check(quotient == W'(15'h4555), "R5 example quotient", quotient, 15'h4555);
        check(quotient == W'(model(64'h3400, 64'h6000)), "R7 result unchanged", quotient,
              model(64'h3400, 64'h6000));
        // R8: quotient held while idle.
        held = quotient;
        repeat (12) @(negedge clk);
        check(quotient == held, "R8 quotient held", quotient, held);
        check(sbq.size() == 0, "R7 no extra done", sbq.size(), 0);

        issue(64'h3FFF, 64'h4000, "min divisor");
        issue(64'h7FFE, 64'h7FFF, "max divisor");
        issue(64'h0000, 64'h5555, "zero dividend");
        issue(64'h0001, 64'h7FFF, "one ulp dividend");
        issue(64'h2AAA, 64'h5555, "half ratio");
        x = 32'h1234_5678;
        for (int k = 0; k < 24; k++) begin
            x = x * 1664525 + 1013904223;
            d = longint'(15'h4000 | (x[29:16] & 14'h3FFF));
            n = longint'(x[14:0]) % d;
            issue(n, d, "random");
        end
        @(negedge clk);
        while (busy || sbq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R3 all results returned", sbq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule